// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block turns one source clock into two banks of divided clocks. The source is picked from three clock inputs. A synthesized high-rate clock is used when the bypass control asks for it. Otherwise one of two reference clocks is used, chosen by a reference select. Each bank divides the source by one of four ratios, picked by its own 2-bit code. The two banks map the same code to different ratio sets. Each bank's divided clock is copied onto four identical output pins.

An active-high master reset holds both dividers in their start state and turns off every output driver. When the reset is released, both banks leave the start state on the same source edge, so their rising edges line up. A new ratio code is taken only at the start of a bank's output period, so a change made while the block runs never produces a short pulse. Every ratio, including the divide-by-6 and divide-by-12 settings, gives a 50% duty cycle. The source mux is a plain clock multiplexer, so the bypass and reference selects should only be changed while the master reset is high.

Top module: `dual_bank_divider`

## Requirements
- R1: Bank A divides the source clock by 2, 4, 6 or 8 for `ratio_a` codes 00, 01, 10 and 11.
- R2: Bank B divides the source clock by 4, 6, 8 or 12 for `ratio_b` codes 00, 01, 10 and 11. Every high or low phase of bank B lasts at least two source cycles.
- R3: While `master_rst` is high, `out_en` is 0 and all eight outputs are high impedance. On each source edge that samples `master_rst` high, both dividers return to their start state with the output high.
- R4: While `master_rst` is low, `out_en` is 1 and the outputs carry the divided clocks.
- R5: With `use_synth` = 1, the dividers count edges of `synth_clk`.
- R6: With `use_synth` = 0, the dividers count edges of `ref_clk0` when `ref_sel` = 0 and of `ref_clk1` when `ref_sel` = 1.
- R7: The four bits of `qa_o` are always equal, and so are the four bits of `qb_o`.
- R8: Every output is high for exactly N/2 source cycles and low for N/2 source cycles, where N is the bank's ratio.
- R9: Both banks are high during the first N/2 source cycles after reset release. After k source edges counted from the release, a bank with ratio N is high exactly when (k mod N) < N/2.
- R10: A ratio code that changes while the block runs takes effect at the first source edge on which that bank's output goes from low to high. The period in progress finishes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| synth_clk | input | 1 | Synthesized high-rate source clock |
| ref_clk0 | input | 1 | Reference clock 0 |
| ref_clk1 | input | 1 | Reference clock 1 |
| use_synth | input | 1 | 1: clock the dividers from synth_clk; 0: from the selected reference |
| ref_sel | input | 1 | 0: ref_clk0, 1: ref_clk1 |
| master_rst | input | 1 | Active-high master reset and output disable |
| ratio_a | input | 2 | Bank A ratio code |
| ratio_b | input | 2 | Bank B ratio code |
| qa_o | output | 4 | Bank A replicated outputs, tri-stated |
| qb_o | output | 4 | Bank B replicated outputs, tri-stated |
| out_en | output | 1 | Enable flag that drives the output tri-state drivers |

## Verification
The bench tries all sixteen pairs of ratio codes and compares every output sample with (k mod N) < N/2. This catches a wrong entry in the ratio map, an off-by-one in the half-period counter, and a bank that starts low or one edge late and so breaks alignment. Runs on each reference input, with bench clocks of different periods, show up a source mux that picks the wrong input, because the edge counts no longer match. A ratio change in the middle of a period, on both banks, catches a divider that reloads at once: it would cut the current phase short and move every later edge. A reset raised in the middle of a run checks that the outputs are disabled at once and that the block then restarts cleanly.

// File: rtl/clkdiv_pkg.sv
// Shared widths, types and the ratio map for the dual-bank divider.
// Assumes 2-bit ratio codes and half-period counts of at most 6 cycles.
package clkdiv_pkg;
    localparam int SEL_W    = 2;
    localparam int HALF_MAX = 6;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    typedef logic [SEL_W-1:0] ratio_code_t;
    typedef logic [CNT_W-1:0] half_t;

    // Half-period length in source cycles for a bank and its ratio code.
    function automatic half_t half_of(input logic bank_b, input ratio_code_t code);
        half_t h;
        if (!bank_b) begin
            h = half_t'(code) + half_t'(1);
        end else begin
            case (code)
                2'd0:    h = half_t'(2);
                2'd1:    h = half_t'(3);
                2'd2:    h = half_t'(4);
                default: h = half_t'(6);
            endcase
        end
        return h;
    endfunction
endpackage

// File: rtl/clk_src_sel.sv
// Source clock multiplexer. It picks the synthesized clock or one of
// two references. It assumes the selects change only while the dividers
// are held in reset, so any glitch on the mux output does no harm.
module clk_src_sel (
    input  logic synth_clk,
    input  logic ref_clk0,
    input  logic ref_clk1,
    input  logic use_synth,
    input  logic ref_sel,
    output logic src_clk
);
    logic ref_clk;

    // Pick the reference first, then choose between it and the synthesized clock.
    always_comb begin
        ref_clk = ref_sel ? ref_clk1 : ref_clk0;
        src_clk = use_synth ? synth_clk : ref_clk;
    end
endmodule

// File: rtl/div_bank.sv
// One divider bank. It toggles its output every half-period count of
// source cycles, so every ratio has a 50% duty cycle. A new ratio code
// is taken only on the edge where the output goes from low to high.
// Synchronous active-low reset; the start state holds the output high.
module div_bank
    import clkdiv_pkg::*;
#(
    parameter bit BANK_B = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  ratio_code_t code,
    output logic        div_o
);
    half_t half_q;
    half_t cnt_q;
    logic  out_q;
    logic  wrap;

    // End of the current half period.
    always_comb wrap = (cnt_q == half_t'(half_q - half_t'(1)));

    // Half-period counter, output toggle and reload at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            out_q  <= 1'b1;
            half_q <= half_of(BANK_B, code);
        end else if (wrap) begin
            cnt_q <= '0;
            out_q <= ~out_q;
            if (!out_q) half_q <= half_of(BANK_B, code);
        end else begin
            cnt_q <= cnt_q + half_t'(1);
        end
    end

    assign div_o = out_q;
endmodule

// File: rtl/fanout_drv.sv
// Copies one divided clock onto WIDTH tri-state pins.
// With the enable low, every pin is left floating.
module fanout_drv #(
    parameter int WIDTH = 4
) (
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    // Drive the replicas, or release them.
    assign q = en ? {WIDTH{din}} : {WIDTH{1'bz}};
endmodule

// File: rtl/dual_bank_divider.sv
// Top level: source select, two divider banks with their own ratio maps,
// and the replicated tri-state outputs. Both banks leave reset on the same
// source edge. The active-high master reset becomes the banks' synchronous
// active-low reset and also clears the output enable at once.
module dual_bank_divider
    import clkdiv_pkg::*;
#(
    parameter int FANOUT = 4
) (
    input  logic              synth_clk,
    input  logic              ref_clk0,
    input  logic              ref_clk1,
    input  logic              use_synth,
    input  logic              ref_sel,
    input  logic              master_rst,
    input  logic [SEL_W-1:0]  ratio_a,
    input  logic [SEL_W-1:0]  ratio_b,
    output logic [FANOUT-1:0] qa_o,
    output logic [FANOUT-1:0] qb_o,
    output logic              out_en
);
    localparam int NBANK = 2;

    logic        src_clk;
    logic        run_n;
    ratio_code_t codes [NBANK];
    logic [NBANK-1:0] div_w;
    logic        a_div;
    logic        b_div;

    clk_src_sel u_sel (
        .synth_clk (synth_clk),
        .ref_clk0  (ref_clk0),
        .ref_clk1  (ref_clk1),
        .use_synth (use_synth),
        .ref_sel   (ref_sel),
        .src_clk   (src_clk)
    );

    // Reset polarity for the banks and the output enable.
    always_comb begin
        run_n  = ~master_rst;
        out_en = ~master_rst;
    end

    // Route each bank's ratio code to its own slot.
    always_comb begin
        codes[0] = ratio_a;
        codes[1] = ratio_b;
    end

    genvar g;
    generate
        for (g = 0; g < NBANK; g++) begin : g_bank
            div_bank #(.BANK_B(g == 1)) u_bank (
                .clk   (src_clk),
                .rst_n (run_n),
                .code  (codes[g]),
                .div_o (div_w[g])
            );
        end
    endgenerate

    assign a_div = div_w[0];
    assign b_div = div_w[1];

    fanout_drv #(.WIDTH(FANOUT)) u_drv_a (.en(out_en), .din(a_div), .q(qa_o));
    fanout_drv #(.WIDTH(FANOUT)) u_drv_b (.en(out_en), .din(b_div), .q(qb_o));
endmodule

// File: rtl/divider_chk.sv
// Checker for dual_bank_divider. It measures the high and low run
// lengths of both divided clocks on the source clock and checks reset hold,
// 50% duty and the minimum run length of bank B.
module divider_chk (
    input logic src_clk,
    input logic master_rst,
    input logic a_clk,
    input logic b_clk
);
    logic       a_prev, b_prev, a_ok, b_ok;
    logic [3:0] a_run, b_run, a_hi, b_hi;

    // Track bank A run lengths and the last high-phase length.
    always_ff @(posedge src_clk) begin
        if (master_rst) begin
            a_prev <= 1'b1; a_run <= '0; a_hi <= '0; a_ok <= 1'b0;
        end else begin
            a_prev <= a_clk;
            a_run  <= (a_clk != a_prev) ? 4'd1 : a_run + 4'd1;
            if (a_clk != a_prev && a_prev) begin
                a_hi <= a_run; a_ok <= 1'b1;
            end
        end
    end

    // Track bank B run lengths and the last high-phase length.
    always_ff @(posedge src_clk) begin
        if (master_rst) begin
            b_prev <= 1'b1; b_run <= '0; b_hi <= '0; b_ok <= 1'b0;
        end else begin
            b_prev <= b_clk;
            b_run  <= (b_clk != b_prev) ? 4'd1 : b_run + 4'd1;
            if (b_clk != b_prev && b_prev) begin
                b_hi <= b_run; b_ok <= 1'b1;
            end
        end
    end

    assert_reset_hold_R3: assert property (@(posedge src_clk)
        master_rst |=> (a_clk && b_clk));

    assert_b_min_run_R2: assert property (@(posedge src_clk) disable iff (master_rst)
        $fell(b_clk) |=> !b_clk);

    assert_a_even_duty_R8: assert property (@(posedge src_clk) disable iff (master_rst)
        (a_clk && !a_prev && a_ok) |-> (a_run == a_hi));

    assert_b_even_duty_R8: assert property (@(posedge src_clk) disable iff (master_rst)
        (b_clk && !b_prev && b_ok) |-> (b_run == b_hi));
endmodule

bind dual_bank_divider divider_chk u_chk (
    .src_clk    (src_clk),
    .master_rst (master_rst),
    .a_clk      (a_div),
    .b_clk      (b_div)
);

// File: tb/sim_dual_bank_divider.sv
// Bench: sweeps all ratio-code pairs and all three clock sources, plus a
// ratio change in mid-run and a reset in mid-run. Expected outputs are
// computed from the edge count since reset release.
module sim_dual_bank_divider;
    logic synth_clk = 1'b0;
    logic ref_clk0  = 1'b0;
    logic ref_clk1  = 1'b0;
    logic use_synth = 1'b1;
    logic ref_sel   = 1'b0;
    logic master_rst = 1'b1;
    logic [1:0] ratio_a = 2'd0;
    logic [1:0] ratio_b = 2'd0;
    logic [3:0] qa_o, qb_o;
    logic out_en;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5  synth_clk = ~synth_clk;
    always #8  ref_clk0  = ~ref_clk0;
    always #11 ref_clk1  = ~ref_clk1;

    dual_bank_divider u0 (
        .synth_clk (synth_clk), .ref_clk0 (ref_clk0), .ref_clk1 (ref_clk1),
        .use_synth (use_synth), .ref_sel (ref_sel), .master_rst (master_rst),
        .ratio_a (ratio_a), .ratio_b (ratio_b),
        .qa_o (qa_o), .qb_o (qb_o), .out_en (out_en)
    );

    function automatic int full_a(int c);
        return (c + 1) * 2;
    endfunction

    function automatic int full_b(int c);
        case (c)
            0: return 4;
            1: return 6;
            2: return 8;
            default: return 12;
        endcase
    endfunction

    // src 0: synthesized clock (R5), 1: ref_clk0, 2: ref_clk1 (R6)
    task automatic edge_wait(int src, bit pos);
        case (src)
            0: if (pos) @(posedge synth_clk); else @(negedge synth_clk);
            1: if (pos) @(posedge ref_clk0);  else @(negedge ref_clk0);
            default: if (pos) @(posedge ref_clk1); else @(negedge ref_clk1);
        endcase
    endtask

    task automatic check_outs(string tag, int k, logic ea, logic eb);
        n_cmp++;
        if (qa_o !== {4{ea}}) begin
            n_bad++;
            $display("FAIL R1 R7 R8 R9 %s bank A k=%0d: got %b expected %b", tag, k, qa_o, {4{ea}});
        end
        n_cmp++;
        if (qb_o !== {4{eb}}) begin
            n_bad++;
            $display("FAIL R2 R7 R8 R9 %s bank B k=%0d: got %b expected %b", tag, k, qb_o, {4{eb}});
        end
        n_cmp++;
        if (out_en !== 1'b1) begin
            n_bad++;
            $display("FAIL R4 %s out_en k=%0d: got %b expected 1", tag, k, out_en);
        end
    endtask

    task automatic check_off(string tag);
        n_cmp++;
        if (out_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R3 %s out_en during reset: got %b expected 0", tag, out_en);
        end
    endtask

    // Hold reset on the chosen source, check outputs off, then release at a falling edge.
    task automatic start(int sa, int sb, int src);
        master_rst = 1'b1;
        use_synth  = (src == 0);
        ref_sel    = (src == 2);
        ratio_a    = 2'(sa);
        ratio_b    = 2'(sb);
        repeat (3) edge_wait(src, 1'b1);
        edge_wait(src, 1'b0);
        check_off("start");
        master_rst = 1'b0;
    endtask

    // R1 R2 R5 R6 R8 R9: compare each sample with (k mod N) < N/2.
    task automatic sweep(int sa, int sb, int src, int len);
        int na, nb;
        na = full_a(sa);
        nb = full_b(sb);
        start(sa, sb, src);
        for (int k = 1; k <= len; k++) begin
            edge_wait(src, 1'b1);
            edge_wait(src, 1'b0);
            check_outs($sformatf("sa=%0d sb=%0d src=%0d", sa, sb, src), k,
                       (k % na) < na / 2, (k % nb) < nb / 2);
        end
    endtask

    initial begin
        for (int sa = 0; sa < 4; sa++)
            for (int sb = 0; sb < 4; sb++)
                sweep(sa, sb, 0, 48);
        sweep(1, 2, 1, 48);
        sweep(0, 3, 1, 24);
        sweep(3, 1, 2, 48);
        sweep(2, 0, 2, 24);

        // R10: A goes from /8 to /2 after edge 3 and B from /4 to /12 after
        // edge 5. Both changes land on the low-to-high edge at k=8.
        start(3, 0, 0);
        for (int k = 1; k <= 40; k++) begin
            logic ea, eb;
            edge_wait(0, 1'b1);
            edge_wait(0, 1'b0);
            ea = (k < 8) ? ((k % 8) < 4) : (((k - 8) % 2) < 1);
            eb = (k < 8) ? ((k % 4) < 2) : (((k - 8) % 12) < 6);
            check_outs("R10 change", k, ea, eb);
            if (k == 3) ratio_a = 2'd0;
            if (k == 5) ratio_b = 2'd3;
        end

        // R3: a reset raised in mid-run disables the outputs at once; then a clean restart.
        master_rst = 1'b1;
        #1;
        check_off("mid-run");
        sweep(2, 3, 0, 24);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule